// File: doc/BRIEF.md
# Turn-Synchronized Acquisition Sync Sequencer

This block produces the sync pulses that start sampling in a bank of digitizers, lined up with the accelerator's revolution marker. It runs entirely on the RF clock. The inputs are a stream of already decoded timing events (an 8-bit code with a one-cycle strobe), a raw external trigger, and a simple write port that loads its delay, count and control registers. The code 0xAA on the event stream marks each turn.

A start arises in one of two ways: when a programmed event code arrives, or when a turn scaler that counts turn markers reaches zero. The trigger that launches the outputs is chosen separately. It can be the start itself, the external input's rising edge, or a start followed by a shared pre-delay counted in turn markers. On a trigger, each of the eight outputs waits its own bucket delay in RF clock periods and then emits a 3-cycle pulse. It repeats this after each later turn marker until its own turn count is used up. In single-shot mode only the first trigger after a control write has any effect. Setting the top bit of a control write clears all sequencing state.

Top module: `turnSyncSeq`

## Requirements
- R1: While reset is asserted and after it is released, every sync output is low until a trigger has been processed.
- R2: Control register index 18, bits 7:6 select the start source. Value 00 starts when the event code equals the start code register (index 19, bits 7:0). Value 01 produces no start. A non-matching code never starts.
- R3: With start source 10, the turn scaler is used. Writing index 16 loads both the reload value and the count. On each turn marker (code 0xAA), a zero count produces a start and reloads the count; any other count is decremented.
- R4: With trigger source 00 (control bits 5:4), a start arms a pre-delay of P turns, where P is index 17, bits 5:0, if control bit 0 is set and 0 otherwise. The trigger occurs on the (P+1)-th turn marker after the start. A start while the pre-delay is pending is ignored.
- R5: With trigger source 01, each rising edge of the external input is a trigger, regardless of the event stream.
- R6: With trigger source 10, each start is itself the trigger.
- R7: For output i, the bucket delay D is index i, bits 10:0, if control bit 1 is set and 0 otherwise. The output's first pulse begins D+2 clock edges after the edge that samples the trigger condition.
- R8: Output i emits G pulses per trigger, where G is index 8+i, bits 10:0. The first pulse follows the trigger. Each later pulse begins D+2 edges after the edge sampling a turn marker that arrives once the previous pulse has begun. With G = 0 the output stays low.
- R9: Every sync pulse is high for exactly 3 consecutive clock cycles.
- R10: With control bit 12 = 0, every trigger is used. With bit 12 = 1, only the first trigger after a control write is used.
- R11: A trigger that arrives while an output is still counting its turns is ignored by that output.
- R12: A control write with bit 15 set stores the other control bits and clears the pre-delay, the single-shot flag and all outputs. The scaler count is reloaded. All outputs are low from the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtStb | input | 1 | Decoded event valid for one cycle |
| evtCode | input | 8 | Decoded event code |
| extTrig | input | 1 | External trigger, rising edge used |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register index |
| regWdata | input | 16 | Register write data |
| syncOut | output | 8 | Digitizer sync pulses, one per output |

## Verification
The pulse-width properties assume that turn markers are spaced further apart than the longest bucket delay plus the pulse length, so pulses from successive turns on one output never merge. The stimulus keeps events 40 cycles apart against a largest delay of 21. The properties also assume that no trigger condition lands in the cycle right after a control write, so the delay-enable bit is settled. The stimulus waits several cycles after every write. The minimum-width property excuses a pulse that is cut short by a soft clear, because a clear may land mid-pulse.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef struct packed {
    logic clear;
    logic trig;
    logic turn;
    logic delayEn;
  } seqStrb_t;

  typedef enum logic [1:0] {CH_IDLE, CH_ARMED, CH_WAIT} chState_t;
endpackage

// File: rtl/seqCtl.sv
module seqCtl import seqPkg::*; #(
  parameter int EV_W = 8,
  parameter int PRE_W = 6,
  parameter int CNT_W = 11,
  parameter int DAT_W = 16,
  parameter int ADDR_W = 5,
  parameter int REG_SCAL = 16,
  parameter logic [EV_W-1:0] TURN_CODE = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStb,
  input  logic [EV_W-1:0]   evtCode,
  input  logic              extTrig,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DAT_W-1:0]  regWdata,
  output seqStrb_t          strb
);
  localparam int REG_PRE = REG_SCAL + 1;
  localparam int REG_CTRL = REG_SCAL + 2;
  localparam int REG_START = REG_SCAL + 3;

  logic [EV_W-1:0] startCode;
  logic [CNT_W-1:0] scalReload, scalCnt;
  logic [PRE_W-1:0] preDly, preCnt;
  logic [1:0] startSrc, trigSrc;
  logic preEn, dlyEn, singleMode, prePend, shotUsed, extPrev;
  logic isTurn, startHit, preFire, trigRaw, trigOk, ctrlWr, softClr;
  wire unusedBits = ^{regWdata[14:13], regWdata[11:8], regWdata[3:2]};

  assign isTurn = evtStb && (evtCode == TURN_CODE);
  assign ctrlWr = regWe && (regAddr == ADDR_W'(REG_CTRL));
  assign softClr = ctrlWr && regWdata[15];
  assign preFire = prePend && isTurn && (preCnt == '0);
  assign trigOk = trigRaw && !(singleMode && shotUsed);

  always_comb begin
    case (startSrc)
      2'b00:   startHit = evtStb && (evtCode == startCode);
      2'b10:   startHit = isTurn && (scalCnt == '0);
      default: startHit = 1'b0;
    endcase
    case (trigSrc)
      2'b00:   trigRaw = preFire;
      2'b01:   trigRaw = extTrig && !extPrev;
      2'b10:   trigRaw = startHit;
      default: trigRaw = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCode <= '0; scalReload <= '0; scalCnt <= '0; preDly <= '0; preCnt <= '0;
      startSrc <= '0; trigSrc <= '0; preEn <= 1'b0; dlyEn <= 1'b0; singleMode <= 1'b0;
      prePend <= 1'b0; shotUsed <= 1'b0; extPrev <= 1'b0; strb <= '0;
    end else begin
      extPrev <= extTrig;
      strb.clear <= softClr;
      strb.trig <= trigOk && !softClr;
      strb.turn <= isTurn && !softClr;
      strb.delayEn <= dlyEn;
      if (softClr) begin
        prePend <= 1'b0;
        shotUsed <= 1'b0;
        scalCnt <= scalReload;
      end else begin
        if (regWe && regAddr == ADDR_W'(REG_SCAL)) scalCnt <= regWdata[CNT_W-1:0];
        else if (isTurn) scalCnt <= (scalCnt == '0) ? scalReload : scalCnt - 1'b1;
        if (trigSrc == 2'b00 && startHit && !prePend) begin
          prePend <= 1'b1;
          preCnt <= preEn ? preDly : '0;
        end else if (prePend && isTurn) begin
          if (preCnt == '0) prePend <= 1'b0;
          else preCnt <= preCnt - 1'b1;
        end
        if (ctrlWr) shotUsed <= 1'b0;
        else if (trigOk && singleMode) shotUsed <= 1'b1;
      end
      if (ctrlWr) begin
        preEn <= regWdata[0];
        dlyEn <= regWdata[1];
        trigSrc <= regWdata[5:4];
        startSrc <= regWdata[7:6];
        singleMode <= regWdata[12];
      end
      if (regWe && regAddr == ADDR_W'(REG_SCAL)) scalReload <= regWdata[CNT_W-1:0];
      if (regWe && regAddr == ADDR_W'(REG_PRE)) preDly <= regWdata[PRE_W-1:0];
      if (regWe && regAddr == ADDR_W'(REG_START)) startCode <= regWdata[EV_W-1:0];
    end
  end
endmodule

// File: rtl/seqPath.sv
module seqPath import seqPkg::*; #(
  parameter int NUM_OUT = 8,
  parameter int DLY_W = 11,
  parameter int CNT_W = 11,
  parameter int DAT_W = 16,
  parameter int ADDR_W = 5,
  parameter int PULSE_LEN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrb_t           strb,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DAT_W-1:0]   regWdata,
  output logic [NUM_OUT-1:0] syncOut
);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);
  localparam int WID_W = (DLY_W > CNT_W) ? DLY_W : CNT_W;

  wire unusedBits = ^regWdata[DAT_W-1:WID_W];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    logic [DLY_W-1:0] bucket, dcnt;
    logic [CNT_W-1:0] gate, rem;
    logic [PLS_W-1:0] pls;
    chState_t st;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bucket <= '0;
        gate <= '0;
      end else if (regWe) begin
        if (regAddr == ADDR_W'(i)) bucket <= regWdata[DLY_W-1:0];
        if (regAddr == ADDR_W'(NUM_OUT + i)) gate <= regWdata[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= CH_IDLE; dcnt <= '0; rem <= '0; pls <= '0;
      end else if (strb.clear) begin
        st <= CH_IDLE; rem <= '0; pls <= '0;
      end else begin
        if (pls != '0) pls <= pls - 1'b1;
        case (st)
          CH_IDLE: if (strb.trig && gate != '0) begin
            rem <= gate;
            dcnt <= strb.delayEn ? bucket : '0;
            st <= CH_WAIT;
          end
          CH_ARMED: if (strb.turn) begin
            dcnt <= strb.delayEn ? bucket : '0;
            st <= CH_WAIT;
          end
          default: if (dcnt == '0) begin
            pls <= PLS_W'(PULSE_LEN);
            rem <= rem - 1'b1;
            st <= (rem == CNT_W'(1)) ? CH_IDLE : CH_ARMED;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        endcase
      end
    end

    assign syncOut[i] = (pls != '0);
  end
endmodule

// File: rtl/turnSyncSeq.sv
module turnSyncSeq import seqPkg::*; #(
  parameter int NUM_OUT = 8,
  parameter int DLY_W = 11,
  parameter int CNT_W = 11,
  parameter int PRE_W = 6,
  parameter int EV_W = 8,
  parameter int DAT_W = 16,
  parameter int PULSE_LEN = 3,
  parameter logic [EV_W-1:0] TURN_CODE = 8'hAA,
  localparam int ADDR_W = $clog2(2 * NUM_OUT + 4)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtStb,
  input  logic [EV_W-1:0]    evtCode,
  input  logic               extTrig,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DAT_W-1:0]   regWdata,
  output logic [NUM_OUT-1:0] syncOut
);
  seqStrb_t strb;

  seqCtl #(.EV_W(EV_W), .PRE_W(PRE_W), .CNT_W(CNT_W), .DAT_W(DAT_W), .ADDR_W(ADDR_W),
           .REG_SCAL(2 * NUM_OUT), .TURN_CODE(TURN_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .evtStb(evtStb), .evtCode(evtCode), .extTrig(extTrig),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .strb(strb));

  seqPath #(.NUM_OUT(NUM_OUT), .DLY_W(DLY_W), .CNT_W(CNT_W), .DAT_W(DAT_W),
            .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .syncOut(syncOut));
endmodule

// File: rtl/seqChk.sv
module seqChk #(
  parameter int NUM_OUT = 8,
  parameter int DAT_W = 16,
  parameter int ADDR_W = 5,
  parameter int PULSE_LEN = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DAT_W-1:0]   regWdata,
  input logic [NUM_OUT-1:0] syncOut
);
  localparam int REG_CTRL = 2 * NUM_OUT + 2;
  localparam int RUN_W = $clog2(PULSE_LEN + 2);

  logic clrWr, clrD1, clrD2;
  assign clrWr = regWe && (regAddr == ADDR_W'(REG_CTRL)) && regWdata[DAT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrD1 <= 1'b0;
      clrD2 <= 1'b0;
    end else begin
      clrD1 <= clrWr;
      clrD2 <= clrD1;
    end
  end

  always @(negedge clk) begin
    if (!rstN) p_reset_low_r1: assert (syncOut == '0);
  end

  p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |-> ##2 (syncOut == '0));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_run
    logic [RUN_W-1:0] runLen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runLen <= '0;
      else if (syncOut[i] && runLen < RUN_W'(PULSE_LEN + 1)) runLen <= runLen + 1'b1;
      else if (!syncOut[i]) runLen <= '0;
    end

    p_width_max_r9: assert property (@(posedge clk) disable iff (!rstN)
      syncOut[i] |-> (runLen < RUN_W'(PULSE_LEN)));

    p_width_min_r9: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(syncOut[i]) && !clrD2) |-> (runLen == RUN_W'(PULSE_LEN)));
  end
endmodule

bind turnSyncSeq seqChk #(.NUM_OUT(NUM_OUT), .DAT_W(DAT_W), .ADDR_W(ADDR_W),
                          .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .syncOut(syncOut));

// File: tb/turnSyncSeq_tb.sv
`timescale 1ns/1ps
module turnSyncSeq_tb;
  localparam int N = 8;
  localparam int TURN = 8'hAA;
  localparam int REG_SCAL = 16, REG_PRE = 17, REG_CTRL = 18, REG_START = 19;

  logic clk = 1'b0, rstN = 1'b0, evtStb = 1'b0, extTrig = 1'b0, regWe = 1'b0;
  logic [7:0] evtCode = '0;
  logic [4:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [N-1:0] syncOut;

  always #2.5 clk = ~clk;

  turnSyncSeq u_dut (.clk(clk), .rstN(rstN), .evtStb(evtStb), .evtCode(evtCode),
    .extTrig(extTrig), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .syncOut(syncOut));

  int vectors = 0, miscompares = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int cyc;
  int mBucket[N], mGate[N], mSt[N], mRem[N], mFire[N], mPUntil[N];
  bit mExp[N];
  int mScalRel, mScalCnt, mPre, mPreCnt, mStartCode, mTrigSrc, mStartSrc;
  bit mPend, mShot, mExtPrev, mClrPend, mPreEn, mDlyEn, mSingle;

  always @(posedge clk) begin
    bit isTurn, startHit, preFire, trigRaw, trig, softW, cTrig, cTurn;
    if (!rstN) begin
      cyc = 0;
      for (int c = 0; c < N; c++) begin
        mBucket[c] = 0; mGate[c] = 0; mSt[c] = 0; mRem[c] = 0;
        mFire[c] = -1; mPUntil[c] = -1; mExp[c] = 1'b0;
      end
      mScalRel = 0; mScalCnt = 0; mPre = 0; mPreCnt = 0; mStartCode = 0;
      mTrigSrc = 0; mStartSrc = 0; mPend = 0; mShot = 0; mExtPrev = 0;
      mClrPend = 0; mPreEn = 0; mDlyEn = 0; mSingle = 0;
    end else begin
      cyc++;
      isTurn = evtStb && evtCode == 8'(TURN);
      startHit = (mStartSrc == 0) ? (evtStb && int'(evtCode) == mStartCode) :
                 (mStartSrc == 2) ? (isTurn && mScalCnt == 0) : 1'b0;
      preFire = mPend && isTurn && mPreCnt == 0;
      trigRaw = (mTrigSrc == 0) ? preFire : (mTrigSrc == 1) ? (extTrig && !mExtPrev) :
                (mTrigSrc == 2) ? startHit : 1'b0;
      trig = trigRaw && !(mSingle && mShot);
      softW = regWe && regAddr == 5'(REG_CTRL) && regWdata[15];
      cTrig = trig && !softW;
      cTurn = isTurn && !softW;
      if (softW) begin
        mPend = 0; mShot = 0; mScalCnt = mScalRel;
      end else begin
        if (regWe && regAddr == 5'(REG_SCAL)) mScalCnt = int'(regWdata[10:0]);
        else if (isTurn) mScalCnt = (mScalCnt == 0) ? mScalRel : mScalCnt - 1;
        if (mTrigSrc == 0 && startHit && !mPend) begin
          mPend = 1; mPreCnt = mPreEn ? mPre : 0;
        end else if (mPend && isTurn) begin
          if (mPreCnt == 0) mPend = 0; else mPreCnt--;
        end
        if (regWe && regAddr == 5'(REG_CTRL)) mShot = 0;
        else if (trig && mSingle) mShot = 1;
      end
      for (int c = 0; c < N; c++) begin
        if (mClrPend) begin
          mSt[c] = 0; mPUntil[c] = -1;
        end else if (mSt[c] == 2 && mFire[c] == cyc) begin
          mPUntil[c] = cyc + 2; mRem[c]--; mSt[c] = (mRem[c] == 0) ? 0 : 1;
        end
        if (cTrig && mSt[c] == 0 && mGate[c] > 0) begin
          mSt[c] = 2; mRem[c] = mGate[c]; mFire[c] = cyc + 2 + (mDlyEn ? mBucket[c] : 0);
        end else if (cTurn && mSt[c] == 1) begin
          mSt[c] = 2; mFire[c] = cyc + 2 + (mDlyEn ? mBucket[c] : 0);
        end
        mExp[c] = (cyc <= mPUntil[c]);
      end
      mClrPend = softW;
      if (regWe) begin
        if (regAddr < 5'(N)) mBucket[regAddr] = int'(regWdata[10:0]);
        else if (regAddr < 5'(2 * N)) mGate[regAddr - 5'(N)] = int'(regWdata[10:0]);
        else if (regAddr == 5'(REG_SCAL)) mScalRel = int'(regWdata[10:0]);
        else if (regAddr == 5'(REG_PRE)) mPre = int'(regWdata[5:0]);
        else if (regAddr == 5'(REG_START)) mStartCode = int'(regWdata[7:0]);
        else if (regAddr == 5'(REG_CTRL)) begin
          mPreEn = regWdata[0]; mDlyEn = regWdata[1]; mTrigSrc = int'(regWdata[5:4]);
          mStartSrc = int'(regWdata[7:6]); mSingle = regWdata[12];
        end
      end
      mExtPrev = extTrig;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < N; c++) begin
        vectors++;
        if (syncOut[c] !== mExp[c]) begin
          miscompares++;
          $display("FAIL %s out%0d cycle %0d: syncOut=%0b expected %0b",
                   curReq, c, cyc, syncOut[c], mExp[c]);
        end
      end
    end
  end

  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = 5'(a); regWdata = 16'(d);
    @(negedge clk);
    regWe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic evt(int code);
    evtStb = 1'b1; evtCode = 8'(code);
    @(negedge clk);
    evtStb = 1'b0;
    repeat (39) @(negedge clk);
  endtask

  task automatic turns(int n);
    repeat (n) evt(TURN);
  endtask

  task automatic extPulse();
    extTrig = 1'b1;
    repeat (5) @(negedge clk);
    extTrig = 1'b0;
    repeat (35) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    vectors++;
    if (syncOut !== '0) begin
      miscompares++;
      $display("FAIL R1 reset state: syncOut=%0h expected 0", syncOut);
    end
    for (int i = 0; i < N; i++) begin
      wr(i, 3 * i);
      wr(N + i, (i == 7) ? 0 : (i % 3) + 1);
    end
    turns(2);                                  // R1: idle after reset, no trigger yet

    curReq = "R6/R7/R8";                       // start event triggers directly, delays on
    wr(REG_START, 8'h5C);
    wr(REG_CTRL, 16'h0002 | (2 << 4));
    evt(8'h5C); turns(4);

    curReq = "R11";                            // second start during counting is ignored
    evt(8'h5C); evt(8'h5C); turns(4);

    curReq = "R2";                             // wrong code, then start source 01
    evt(8'h33); turns(2);
    wr(REG_CTRL, 16'h0002 | (2 << 4) | (1 << 6));
    evt(8'h5C); turns(3);

    curReq = "R4";                             // pre-delay of 2 turns, then disabled
    wr(REG_PRE, 2);
    wr(REG_CTRL, 16'h0003);
    evt(8'h5C); evt(8'h5C); turns(7);
    wr(REG_CTRL, 16'h0002);
    evt(8'h5C); turns(5);

    curReq = "R3";                             // periodic start from turn scaler
    wr(REG_SCAL, 3);
    wr(REG_CTRL, 16'h0002 | (2 << 4) | (2 << 6));
    turns(14);

    curReq = "R5";                             // external edge, no events needed
    wr(REG_CTRL, 16'h0002 | (1 << 4) | (1 << 6));
    extPulse(); turns(4);

    curReq = "R10";                            // single-shot, re-armed by control write
    wr(REG_CTRL, 16'h1002 | (1 << 4) | (1 << 6));
    extPulse(); turns(4);
    extPulse(); turns(4);
    wr(REG_CTRL, 16'h1002 | (1 << 4) | (1 << 6));
    extPulse(); turns(4);

    curReq = "R7";                             // delay timer disabled: all delays zero
    wr(REG_CTRL, 16'h0000 | (1 << 4) | (1 << 6));
    extPulse(); turns(4);

    curReq = "R12";                            // soft clear mid-sequence
    wr(REG_CTRL, 16'h0002 | (1 << 4) | (1 << 6));
    extTrig = 1'b1;
    repeat (5) @(negedge clk);
    extTrig = 1'b0;
    repeat (5) @(negedge clk);
    wr(REG_CTRL, 16'h8002 | (1 << 4) | (1 << 6));
    turns(4);
    curReq = "R12/R9";                         // operation resumes after the clear
    extPulse(); turns(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog %s: run did not complete, expected completion", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule